// File: doc/BRIEF.md
# PCM Transmit Slot Formatter

This block assembles one 16-bit transmit slot from a PCM sample and a small set of programmable control bits, then serialises that slot. A narrower PCM sample (13, 14 or 15 significant bits) is presented left-aligned in a 16-bit word. The unused low-order positions are overwritten with zero to three control bits. Those bits come from a configuration field, and a length setting chooses how many of them are used.

The length setting and the control bits live in configuration registers. They change only on a write strobe. A load strobe captures the formatted word into a holding register and into a shift register. Each bit-clock enable then moves the slot out one bit, most significant bit first. After the sixteenth bit the serial line idles low until the next load.

Top module: `pcm_slot_formatter`

## Requirements
- R1: After reset the length setting and control bits are zero, `slot_word` is 0, `ser_out` is 0 and `active` is 0.
- R2: With length setting 0, the captured slot equals `sample` unchanged.
- R3: With length setting 1, slot bit 0 is control bit 0, and slot bits 15..1 are `sample[15:1]`.
- R4: With length setting 2, slot bits 1..0 are control bits 1..0, and slot bits 15..2 are `sample[15:2]`.
- R5: With length setting 3, slot bits 2..0 are control bits 2..0, and slot bits 15..3 are `sample[15:3]`.
- R6: `cfg_mode` and `cfg_ctl` are taken in only on a cycle with `cfg_wr` high, and only for loads in later cycles. Changes on those pins without the strobe have no effect on any later slot.
- R7: One cycle after `load` is sampled high, `slot_word` holds the formatted word, `active` is 1 and `ser_out` shows slot bit 15.
- R8: Each cycle with `bit_en` high while active advances `ser_out` to the next lower slot bit. After 16 such cycles `active` falls and `ser_out` stays 0.
- R9: `bit_en` while not active changes nothing. A `load` while active restarts the slot with the new word.
- R10: When `load` and `bit_en` are high in the same cycle, the load wins and no bit of the new slot is skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the length setting and control bits |
| cfg_mode | input | 2 | Number of control bits to append (0 to 3) |
| cfg_ctl | input | 3 | Control bit values, bit 2 is sent first |
| load | input | 1 | Capture a new slot from `sample` |
| sample | input | 16 | Left-aligned PCM sample |
| bit_en | input | 1 | Bit-clock enable, one serial bit per pulse |
| slot_word | output | 16 | Last captured formatted slot |
| ser_out | output | 1 | Serial slot data, MSB first |
| active | output | 1 | High while slot bits remain to be sent |

## Verification
A wrong length setting or stale control register shows one cycle after the next load: `slot_word` carries the wrong low bits. The same wrong bits appear on `ser_out` during the last three bit times of that slot. A wrong bit counter or shift register shows on the first bit enable after which the serial line or `active` departs from the expected bit sequence. A per-cycle reference model catches such a departure in the cycle it first appears. It is driven with all four length settings, idle enables, reloads in mid-slot and coincident load and enable.

// File: rtl/pcm_slot_pkg.sv
// Package: shared default dimensions for the PCM slot formatter.
// Assumes the slot is wider than the control field.
package pcm_slot_pkg;
    localparam int SLOT_W_DEF = 16;
    localparam int CTL_W_DEF  = 3;

    // Width of a field that can count 0..ctl_w control bits.
    function automatic int len_width(input int ctl_w);
        return $clog2(ctl_w + 1);
    endfunction
endpackage

// File: rtl/pcm_slot_cfg.sv
// Module: configuration registers for the appended-bit length and values.
// Assumes a single write strobe updates both fields together.
module pcm_slot_cfg #(
    parameter int CTL_W  = pcm_slot_pkg::CTL_W_DEF,
    parameter int MODE_W = pcm_slot_pkg::len_width(CTL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [CTL_W-1:0]  cfg_ctl,
    output logic [MODE_W-1:0] mode_q,
    output logic [CTL_W-1:0]  ctl_q
);
    // Hold the length setting and control bits; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctl_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= cfg_mode;
            ctl_q  <= cfg_ctl;
        end
    end

    // R6: without a write strobe the registers keep their value.
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(mode_q) && $stable(ctl_q)));

    // R1: a reset cycle leaves both fields cleared.
    p_cfg_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (mode_q == '0 && ctl_q == '0));
endmodule

// File: rtl/pcm_slot_assembler.sv
// Module: combinational slot builder. The low `mode` bits of the sample
// are replaced by the same-numbered control bits; the rest pass through.
// Assumes mode never exceeds CTL_W.
module pcm_slot_assembler #(
    parameter int SLOT_W = pcm_slot_pkg::SLOT_W_DEF,
    parameter int CTL_W  = pcm_slot_pkg::CTL_W_DEF,
    parameter int MODE_W = pcm_slot_pkg::len_width(CTL_W)
) (
    input  logic [SLOT_W-1:0] sample,
    input  logic [CTL_W-1:0]  ctl,
    input  logic [MODE_W-1:0] mode,
    output logic [SLOT_W-1:0] fmt
);
    for (genvar i = 0; i < SLOT_W; i++) begin : g_bit
        if (i < CTL_W) begin : g_ctl
            // Pick control bit i when the length setting covers position i.
            assign fmt[i] = (int'(mode) > i) ? ctl[i] : sample[i];
        end else begin : g_pcm
            // Upper positions always carry the PCM sample.
            assign fmt[i] = sample[i];
        end
    end
endmodule

// File: rtl/pcm_slot_shifter.sv
// Module: captures a formatted slot on load and shifts it out MSB first,
// one bit per enable. Assumes load has priority over the bit enable.
module pcm_slot_shifter #(
    parameter int SLOT_W = pcm_slot_pkg::SLOT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              bit_en,
    input  logic [SLOT_W-1:0] fmt,
    output logic [SLOT_W-1:0] slot_word,
    output logic              ser_out,
    output logic              active
);
    localparam int CNT_W = $clog2(SLOT_W + 1);

    logic [SLOT_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;

    // Keep a copy of the last captured slot for observation.
    always_ff @(posedge clk) begin
        if (!rst_n)    slot_word <= '0;
        else if (load) slot_word <= fmt;
    end

    // Load a new slot or shift one bit per enable while bits remain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            bits_left <= '0;
        end else if (load) begin
            shreg     <= fmt;
            bits_left <= CNT_W'(SLOT_W);
        end else if (bit_en && bits_left != '0) begin
            shreg     <= {shreg[SLOT_W-2:0], 1'b0};
            bits_left <= bits_left - 1'b1;
        end
    end

    assign active  = (bits_left != '0);
    assign ser_out = shreg[SLOT_W-1];

    // R7: a load restarts the full slot count and captures the word.
    p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (bits_left == CNT_W'(SLOT_W) && slot_word == $past(fmt)));

    // R8: each enabled bit time moves the next lower bit to the output.
    p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_en && !load) |=> (shreg[SLOT_W-1] == $past(shreg[SLOT_W-2])));

    // R8: the remaining count never exceeds one slot.
    p_cnt_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bits_left <= CNT_W'(SLOT_W));

    // R8: once the slot is exhausted the line is low.
    p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !ser_out);

    // R9: while idle, bit enables leave the shift state untouched.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> ($stable(shreg) && !active));
endmodule

// File: rtl/pcm_slot_formatter.sv
// Module: top of the PCM transmit slot formatter. Wires the configuration
// registers, the slot assembler and the serial shifter.
// Assumes the sample is presented left-aligned and SLOT_W > CTL_W.
module pcm_slot_formatter #(
    parameter int SLOT_W = pcm_slot_pkg::SLOT_W_DEF,
    parameter int CTL_W  = pcm_slot_pkg::CTL_W_DEF,
    parameter int MODE_W = pcm_slot_pkg::len_width(CTL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [CTL_W-1:0]  cfg_ctl,
    input  logic              load,
    input  logic [SLOT_W-1:0] sample,
    input  logic              bit_en,
    output logic [SLOT_W-1:0] slot_word,
    output logic              ser_out,
    output logic              active
);
    logic [MODE_W-1:0] mode_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [SLOT_W-1:0] fmt;

    pcm_slot_cfg #(.CTL_W(CTL_W), .MODE_W(MODE_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_mode (cfg_mode),
        .cfg_ctl  (cfg_ctl),
        .mode_q   (mode_q),
        .ctl_q    (ctl_q)
    );

    pcm_slot_assembler #(.SLOT_W(SLOT_W), .CTL_W(CTL_W), .MODE_W(MODE_W)) u_asm (
        .sample (sample),
        .ctl    (ctl_q),
        .mode   (mode_q),
        .fmt    (fmt)
    );

    pcm_slot_shifter #(.SLOT_W(SLOT_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .bit_en    (bit_en),
        .fmt       (fmt),
        .slot_word (slot_word),
        .ser_out   (ser_out),
        .active    (active)
    );

    // R2: with no control bits the assembled word is the sample itself.
    p_mode0_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0) |-> (fmt == sample));

    // R5: positions above the control field always carry the sample.
    p_upper_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fmt[SLOT_W-1:CTL_W] == sample[SLOT_W-1:CTL_W]);
endmodule

// File: tb/sim_pcm_slot_formatter.sv
module sim_pcm_slot_formatter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_mode = '0;
    logic [2:0]  cfg_ctl = '0;
    logic        load = 1'b0;
    logic [15:0] sample = '0;
    logic        bit_en = 1'b0;
    logic [15:0] slot_word;
    logic        ser_out;
    logic        active;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    // Reference model state
    int     m_mode = 0;
    int     m_ctl  = 0;
    int     m_word = 0;
    bit     m_q[$];

    always #4 clk = ~clk;

    pcm_slot_formatter u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_ctl(cfg_ctl), .load(load), .sample(sample), .bit_en(bit_en),
        .slot_word(slot_word), .ser_out(ser_out), .active(active)
    );

    function automatic int build(input int smp, input int mode, input int ctl);
        int mask;
        mask = (1 << mode) - 1;
        return (smp & ~mask & 16'hFFFF) | (ctl & mask);
    endfunction

    // Behavioural model, updated on every edge from the applied inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_ctl = 0; m_word = 0; m_q.delete();
        end else begin
            if (load) begin
                m_word = build(int'(sample), m_mode, m_ctl);
                m_q.delete();
                for (int b = 15; b >= 0; b--) m_q.push_back(m_word[b]);
            end else if (bit_en && m_q.size() > 0) begin
                void'(m_q.pop_front());
            end
            if (cfg_wr) begin
                m_mode = int'(cfg_mode);
                m_ctl  = int'(cfg_ctl);
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Wait to mid-cycle and compare all outputs against the model.
    task automatic cyc();
        @(negedge clk);
        if (rst_n) begin
            chk(cur_req, "slot_word", int'(slot_word), m_word & 16'hFFFF);
            chk(cur_req, "ser_out", int'(ser_out), (m_q.size() > 0) ? int'(m_q[0]) : 0);
            chk(cur_req, "active", int'(active), (m_q.size() > 0) ? 1 : 0);
        end
    endtask

    task automatic idle_inputs();
        cfg_wr = 1'b0; load = 1'b0; bit_en = 1'b0;
    endtask

    task automatic shift_all(input int gap);
        for (int b = 0; b < 16; b++) begin
            bit_en = 1'b1; cyc(); bit_en = 1'b0;
            for (int g = 0; g < gap; g++) cyc();
        end
        cyc();
    endtask

    task automatic run_mode(input string req, input int mode, input int ctl, input int smp);
        cur_req = req;
        cfg_mode = 2'(mode); cfg_ctl = 3'(ctl); cfg_wr = 1'b1; cyc(); cfg_wr = 1'b0;
        sample = 16'(smp); load = 1'b1; cyc(); load = 1'b0;
        cyc();
        chk(req, "slot_word formula", int'(slot_word), build(smp, mode, ctl));
        chk("R7", "first bit is slot MSB", int'(ser_out), (build(smp, mode, ctl) >> 15) & 1);
        shift_all(mode);
        chk("R8", "idle after 16 bits", int'(active), 0);
        chk("R8", "line low after slot", int'(ser_out), 0);
    endtask

    initial begin
        #(8 * 20000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cyc(); cyc(); cyc();
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "slot_word after reset", int'(slot_word), 0);
        chk("R1", "ser_out after reset", int'(ser_out), 0);
        chk("R1", "active after reset", int'(active), 0);

        // R6: config pins without strobe must not alter the next slot
        cur_req = "R6";
        cfg_mode = 2'd3; cfg_ctl = 3'd7; cyc(); cyc();
        sample = 16'hAAAA; load = 1'b1; cyc(); load = 1'b0; cyc();
        chk("R6", "no strobe, sample unchanged", int'(slot_word), 16'hAAAA);
        shift_all(0);

        run_mode("R2", 0, 7, 16'h1234);
        run_mode("R3", 1, 1, 16'hFFFE);
        run_mode("R3", 1, 0, 16'hFFFF);
        run_mode("R4", 2, 2, 16'h8001);
        run_mode("R4", 2, 1, 16'h7FFF);
        run_mode("R5", 3, 5, 16'hC3C0);
        run_mode("R5", 3, 2, 16'h0007);

        // R6: strobe in the same cycle as load applies only to later loads
        cur_req = "R6";
        cfg_mode = 2'd1; cfg_ctl = 3'd0; cfg_wr = 1'b1; sample = 16'h00FF; load = 1'b1;
        cyc(); cfg_wr = 1'b0; load = 1'b0; cyc();
        chk("R6", "same-cycle strobe uses old cfg", int'(slot_word), build(16'h00FF, 3, 2));
        shift_all(0);

        // R9: enables while idle do nothing
        cur_req = "R9";
        for (int k = 0; k < 5; k++) begin bit_en = 1'b1; cyc(); end
        bit_en = 1'b0; cyc();
        chk("R9", "idle enables keep line low", int'(ser_out), 0);
        // R9: reload in mid-slot
        sample = 16'hF0F0; load = 1'b1; cyc(); load = 1'b0;
        for (int k = 0; k < 5; k++) begin bit_en = 1'b1; cyc(); end
        bit_en = 1'b0;
        sample = 16'h0F0F; load = 1'b1; cyc(); load = 1'b0; cyc();
        chk("R9", "reload restarts slot", int'(active), 1);
        shift_all(0);

        // R10: load and bit enable together
        cur_req = "R10";
        sample = 16'hB00B; load = 1'b1; bit_en = 1'b1; cyc(); load = 1'b0; bit_en = 1'b0; cyc();
        chk("R10", "no bit skipped on coincident load", int'(ser_out), 1);
        shift_all(0);

        // R8: mixed traffic
        cur_req = "R8";
        for (int k = 0; k < 600; k++) begin
            cfg_wr = ($urandom_range(0, 15) == 0);
            cfg_mode = 2'($urandom_range(0, 3));
            cfg_ctl = 3'($urandom_range(0, 7));
            load = ($urandom_range(0, 24) == 0);
            sample = 16'($urandom);
            bit_en = ($urandom_range(0, 2) != 0);
            cyc();
        end
        idle_inputs();
        cyc();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule